// File: doc/BRIEF.md
# Multi-Width FIFO Access Port for an Eight-Channel Serial Bank

This block is the host-facing slave port of a bank of eight serial channels. A 4 KB memory window is split into eight 512-byte channel regions. A small group of device-wide registers is placed inside the region of channel 0. The host issues single-cycle requests with a word address and a 4-bit byte-enable mask. The number of enabled lanes sets how many bytes the access moves, from one to four. A write to a channel's data port pushes that many bytes into the channel's transmit FIFO in one cycle. A read from the same port pops that many bytes from the receive FIFO in one cycle. A second receive port, the paired port, returns each received byte in the same half-word as its line-status flags, so the two cannot be separated.

On the serial side, each channel has a valid/ready stream that drains its transmit FIFO and a valid/ready stream that fills its receive FIFO. A transmit byte is presented while `tx_valid` is high. It stays on `tx_data` until the cycle in which `tx_ready` is also high. A receive entry is taken in any cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` falls only while the receive FIFO is full, and a producer facing a low `rx_ready` must hold its entry. The FIFOs are simple synchronous circular buffers. `DEPTH` must be a power of two and at least 4.

Top module: `mbp_top`

## Requirements
- R1: `bus_ack` is high exactly in the cycle after each cycle in which `bus_req` is high. `bus_rdata` is valid in that cycle, and it is zero for writes.
- R2: Address bits [11:9] select the channel. Within a region, byte offset 0x100 is the data port, 0x104 is the paired port and 0x108 is the channel status register. Offsets 0x080 to 0x093 reach the device registers only in channel 0; in any other channel they read zero. Unmapped offsets read zero, and writes to them change nothing.
- R3: A write to the data port pushes one byte per enabled lane into that channel's transmit FIFO, in ascending lane order.
- R4: When a data-port write carries more bytes than the transmit FIFO has room for, the bytes that fit are pushed and the rest are dropped. Bit n of device register 0x084 is then set for channel n. Writing 1 to a bit of that register clears it.
- R5: A read from the data port pops min(enabled lanes, receive level) entries. The k-th popped data byte goes to the k-th enabled lane in ascending order, and every other lane reads zero.
- R6: A paired read with byte enables 0x3 or 0xC pops one entry, returned as data in lane 0 or 2 and status in lane 1 or 3. Byte enables 0xF pop two entries: the older one in lanes 1:0, the newer one in lanes 3:2. A pair with no entry behind it reads zero.
- R7: A paired read with any other nonzero byte-enable mask pops nothing and returns zero. It sets the misuse flag, bit 0 of device register 0x088, which stays set until 1 is written to that bit.
- R8: `tx_valid[n]` is high while channel n's transmit FIFO holds data. `tx_data` shows the oldest byte and holds it until it is taken.
- R9: `rx_ready[n]` is low only while channel n's receive FIFO holds `DEPTH` entries. An entry offered while it is low is not stored.
- R10: The channel status register reads the transmit level in bits [7:0] and the receive level in bits [15:8], as they stood before the edge that takes the read.
- R11: Device register 0x080 reads the constant `DEV_ID`. Register 0x08C is a byte-writable scratch word. Register 0x090 reads one bit per channel, set while that receive FIFO is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Host request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address in the window; bits [1:0] are ignored |
| bus_be | input | 4 | Byte-lane enables; their count sets the access width |
| bus_wdata | input | 32 | Write data, lane l in bits [8l+7:8l] |
| bus_ack | output | 1 | Access completion, one cycle after the request |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| tx_valid | output | 8 | Per channel: transmit byte available |
| tx_ready | input | 8 | Per channel: serializer takes the byte |
| tx_data | output | 64 | Per channel transmit byte, channel n in bits [8n+7:8n] |
| rx_valid | input | 8 | Per channel: received entry offered |
| rx_ready | output | 8 | Per channel: receive FIFO can accept |
| rx_data | input | 64 | Per channel received byte |
| rx_stat | input | 64 | Per channel line-status flags of that byte |

## Verification
A request is sampled at one rising edge. The FIFO pointers, the sticky flags and the registered `bus_ack`/`bus_rdata` all update at that same edge. Every bus result is therefore due one cycle after the request, and each bus task reads it at the falling edge that follows that edge. Stream results take one edge as well: a transmit byte taken at an edge leaves `tx_data` by the next falling edge, and a receive entry offered at a falling edge shows in the level from the falling edge after. The bench drives all inputs and samples all outputs on falling edges, and it checks each result against per-channel reference queues.

// File: rtl/mbp_pkg.sv
package mbp_pkg;
  localparam int REGION_W = 9;
  localparam int WORD_W   = REGION_W - 2;

  localparam logic [WORD_W-1:0] W_DEV_LO = 7'h20;
  localparam logic [WORD_W-1:0] W_DEV_HI = 7'h24;
  localparam logic [WORD_W-1:0] W_DATA   = 7'h40;
  localparam logic [WORD_W-1:0] W_PAIR   = 7'h41;
  localparam logic [WORD_W-1:0] W_CHST   = 7'h42;

  typedef enum logic [2:0] {T_NONE, T_DATA, T_PAIR, T_CHST, T_DEV} tgt_e;

  function automatic logic [2:0] popcnt4(input logic [3:0] v);
    return 3'(v[0]) + 3'(v[1]) + 3'(v[2]) + 3'(v[3]);
  endfunction
endpackage

// File: rtl/mbp_decode.sv
module mbp_decode
  import mbp_pkg::*;
#(
  parameter  int CH_W = 3,
  localparam int AW   = CH_W + REGION_W
) (
  input  logic [AW-1:0]   addr,
  output logic [CH_W-1:0] chan,
  output tgt_e            tgt,
  output logic [2:0]      dev_idx
);
  logic [WORD_W-1:0] word;
  logic [1:0]        unused_lo;

  assign word      = addr[REGION_W-1:2];
  assign chan      = addr[AW-1:REGION_W];
  assign unused_lo = addr[1:0];

  always_comb begin
    dev_idx = 3'(word - W_DEV_LO);
    tgt     = T_NONE;
    if (word >= W_DEV_LO && word <= W_DEV_HI) begin
      if (chan == '0) tgt = T_DEV;
    end else if (word == W_DATA) tgt = T_DATA;
    else if (word == W_PAIR)     tgt = T_PAIR;
    else if (word == W_CHST)     tgt = T_CHST;
  end
endmodule

// File: rtl/mbp_fifo.sv
module mbp_fifo #(
  parameter  int W     = 8,
  parameter  int DEPTH = 16,
  parameter  int NPUSH = 1,
  parameter  int NPOP  = 1,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(DEPTH + 1),
  localparam int PSW   = $clog2(NPUSH + 1),
  localparam int PPW   = $clog2(NPOP + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PSW-1:0]            push_n,
  input  logic [NPUSH-1:0][W-1:0]   push_d,
  input  logic [PPW-1:0]            pop_n,
  output logic [NPOP-1:0][W-1:0]    head,
  output logic [LW-1:0]             level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      wptr <= wptr + AW'(push_n);
      rptr <= rptr + AW'(pop_n);
      cnt  <= cnt + LW'(push_n) - LW'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NPUSH; k++) begin
      if (k < int'(push_n)) mem[wptr + AW'(k)] <= push_d[k];
    end
  end

  always_comb begin
    for (int k = 0; k < NPOP; k++) head[k] = mem[rptr + AW'(k)];
  end

  assign level = cnt;
endmodule

// File: rtl/mbp_top.sv
module mbp_top
  import mbp_pkg::*;
#(
  parameter  int          NCH    = 8,
  parameter  int          DEPTH  = 16,
  parameter  logic [31:0] DEV_ID = 32'h51C0_0801,
  localparam int          CH_W   = $clog2(NCH),
  localparam int          ADDR_W = CH_W + REGION_W,
  localparam int          LW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ack,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    tx_valid,
  input  logic [NCH-1:0]    tx_ready,
  output logic [NCH*8-1:0]  tx_data,
  input  logic [NCH-1:0]    rx_valid,
  output logic [NCH-1:0]    rx_ready,
  input  logic [NCH*8-1:0]  rx_data,
  input  logic [NCH*8-1:0]  rx_stat
);
  // decode
  logic [CH_W-1:0] chan;
  tgt_e            tgt;
  logic [2:0]      dev_idx;

  mbp_decode #(.CH_W(CH_W)) u_dec (
    .addr(bus_addr), .chan(chan), .tgt(tgt), .dev_idx(dev_idx)
  );

  // per-channel FIFO views
  logic [LW-1:0]         tx_lvl  [NCH];
  logic [LW-1:0]         rx_lvl  [NCH];
  logic [3:0][15:0]      rx_head [NCH];
  logic [NCH-1:0]        rx_nonempty;

  logic [LW-1:0]    sel_tx_lvl, sel_rx_lvl, room;
  logic [3:0][15:0] sel_rx_head;
  assign sel_tx_lvl  = tx_lvl[chan];
  assign sel_rx_lvl  = rx_lvl[chan];
  assign sel_rx_head = rx_head[chan];
  assign room        = LW'(DEPTH) - sel_tx_lvl;

  // access classification
  logic [2:0] nreq;
  logic       is_wr_data, is_rd_data, is_rd_pair, dev_wr;
  assign nreq       = popcnt4(bus_be);
  assign is_wr_data = bus_req &&  bus_we && tgt == T_DATA;
  assign is_rd_data = bus_req && !bus_we && tgt == T_DATA;
  assign is_rd_pair = bus_req && !bus_we && tgt == T_PAIR;
  assign dev_wr     = bus_req &&  bus_we && tgt == T_DEV;

  // write side: compact enabled lanes into push order
  logic [3:0][7:0] wpack;
  logic [2:0]      tx_push_n;
  logic            ovf_set;
  always_comb begin
    int idx;
    idx   = 0;
    wpack = '0;
    for (int l = 0; l < 4; l++) begin
      if (bus_be[l]) begin
        wpack[2'(idx)] = bus_wdata[l*8 +: 8];
        idx++;
      end
    end
  end

  assign ovf_set   = is_wr_data && (LW'(nreq) > room);
  assign tx_push_n = !is_wr_data ? 3'd0 : (ovf_set ? 3'(room) : nreq);

  // read side: pop counts
  logic [1:0] np;
  int         pbase;
  logic [2:0] pop_data_n, pop_pair_n, rx_pop_n;
  logic       misuse_set;
  always_comb begin
    case (bus_be)
      4'h3:    begin np = 2'd1; pbase = 0; end
      4'hC:    begin np = 2'd1; pbase = 2; end
      4'hF:    begin np = 2'd2; pbase = 0; end
      default: begin np = 2'd0; pbase = 0; end
    endcase
  end

  assign pop_data_n = (LW'(nreq) > sel_rx_lvl) ? 3'(sel_rx_lvl) : nreq;
  assign pop_pair_n = (LW'(np) > sel_rx_lvl) ? 3'(sel_rx_lvl) : 3'(np);
  assign misuse_set = is_rd_pair && np == 2'd0 && bus_be != 4'h0;
  assign rx_pop_n   = is_rd_data ? pop_data_n : (is_rd_pair ? pop_pair_n : 3'd0);

  // device registers
  logic [NCH-1:0] ovf_q;
  logic           misuse_q;
  logic [31:0]    scratch_q, bemask, clr;
  always_comb begin
    for (int l = 0; l < 4; l++) bemask[l*8 +: 8] = {8{bus_be[l]}};
  end
  assign clr = bus_wdata & bemask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q     <= '0;
      misuse_q  <= 1'b0;
      scratch_q <= '0;
    end else begin
      if (dev_wr && dev_idx == 3'd1)
        ovf_q <= (ovf_q & ~clr[NCH-1:0]) | (ovf_set ? NCH'(1) << chan : '0);
      else if (ovf_set)
        ovf_q <= ovf_q | (NCH'(1) << chan);
      if (misuse_set)
        misuse_q <= 1'b1;
      else if (dev_wr && dev_idx == 3'd2 && clr[0])
        misuse_q <= 1'b0;
      if (dev_wr && dev_idx == 3'd3)
        scratch_q <= (scratch_q & ~bemask) | clr;
    end
  end

  // read mux and lane expansion
  logic [31:0] rd_next;
  always_comb begin
    logic [3:0][7:0] rl;
    int idx;
    rl      = '0;
    idx     = 0;
    rd_next = '0;
    case (tgt)
      T_DATA: begin
        for (int l = 0; l < 4; l++) begin
          if (bus_be[l]) begin
            if (idx < int'(pop_data_n)) rl[l] = sel_rx_head[2'(idx)][7:0];
            idx++;
          end
        end
        rd_next = rl;
      end
      T_PAIR: begin
        for (int k = 0; k < 2; k++) begin
          if (k < int'(pop_pair_n)) begin
            rl[2'(pbase + 2*k)]     = sel_rx_head[k][7:0];
            rl[2'(pbase + 2*k + 1)] = sel_rx_head[k][15:8];
          end
        end
        rd_next = rl;
      end
      T_CHST: rd_next = 32'(sel_tx_lvl) | (32'(sel_rx_lvl) << 8);
      T_DEV: begin
        case (dev_idx)
          3'd0:    rd_next = DEV_ID;
          3'd1:    rd_next = 32'(ovf_q);
          3'd2:    rd_next = 32'(misuse_q);
          3'd3:    rd_next = scratch_q;
          3'd4:    rd_next = 32'(rx_nonempty);
          default: rd_next = '0;
        endcase
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_req;
      bus_rdata <= (bus_req && !bus_we) ? rd_next : '0;
    end
  end

  // per-channel FIFOs
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [2:0]       txp_n, rxq_n;
    logic [0:0][7:0]  tx_hd;
    logic [0:0][15:0] rx_in;
    logic             tx_pop, rx_push;

    assign txp_n   = (chan == CH_W'(g)) ? tx_push_n : 3'd0;
    assign rxq_n   = (chan == CH_W'(g)) ? rx_pop_n  : 3'd0;
    assign tx_pop  = tx_valid[g] && tx_ready[g];
    assign rx_push = rx_valid[g] && rx_ready[g];
    assign rx_in   = {rx_stat[g*8 +: 8], rx_data[g*8 +: 8]};

    mbp_fifo #(.W(8), .DEPTH(DEPTH), .NPUSH(4), .NPOP(1)) u_txf (
      .clk(clk), .rst_n(rst_n), .push_n(txp_n), .push_d(wpack),
      .pop_n(tx_pop), .head(tx_hd), .level(tx_lvl[g])
    );
    mbp_fifo #(.W(16), .DEPTH(DEPTH), .NPUSH(1), .NPOP(4)) u_rxf (
      .clk(clk), .rst_n(rst_n), .push_n(rx_push), .push_d(rx_in),
      .pop_n(rxq_n), .head(rx_head[g]), .level(rx_lvl[g])
    );

    assign tx_valid[g]          = tx_lvl[g] != '0;
    assign tx_data[g*8 +: 8]    = tx_hd[0];
    assign rx_ready[g]          = rx_lvl[g] != LW'(DEPTH);
    assign rx_nonempty[g]       = rx_lvl[g] != '0;
  end
endmodule

// File: rtl/mbp_chk.sv
module mbp_chk
  import mbp_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DEPTH = 16,
  parameter int LW    = 5,
  parameter int CH_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_req,
  input logic             bus_we,
  input logic [3:0]       bus_be,
  input logic             bus_ack,
  input logic [31:0]      bus_rdata,
  input tgt_e             tgt,
  input logic [CH_W-1:0]  chan,
  input logic [LW-1:0]    sel_tx_lvl,
  input logic [LW-1:0]    sel_rx_lvl,
  input logic [NCH-1:0]   ovf_q,
  input logic             misuse_q,
  input logic [NCH-1:0]   tx_valid,
  input logic [NCH-1:0]   tx_ready,
  input logic [NCH*8-1:0] tx_data
);
  AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ack); // R1
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !bus_ack); // R1
  AST_WRITE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |=> bus_rdata == 32'h0); // R1
  AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && tgt == T_DATA && $countones(bus_be) > (DEPTH - int'(sel_tx_lvl)))
      |=> ovf_q[$past(chan)]); // R4
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && tgt == T_DATA && sel_rx_lvl == '0) |=> bus_rdata == 32'h0); // R5
  AST_MISUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && tgt == T_PAIR && ($countones(bus_be) % 2) == 1) |=> misuse_q); // R7
  AST_MISUSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && tgt == T_PAIR && ($countones(bus_be) % 2) == 1) |=> bus_rdata == 32'h0); // R7
  AST_MISUSE_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && tgt == T_PAIR && ($countones(bus_be) % 2) == 1)
      |=> sel_rx_lvl >= $past(sel_rx_lvl) || chan != $past(chan)); // R7

  for (genvar g = 0; g < NCH; g++) begin : g_hold
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid[g] && !tx_ready[g]) |=> tx_valid[g] && $stable(tx_data[g*8 +: 8])); // R8
  end
endmodule

bind mbp_top mbp_chk #(.NCH(NCH), .DEPTH(DEPTH), .LW(LW), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_be(bus_be),
  .bus_ack(bus_ack), .bus_rdata(bus_rdata), .tgt(tgt), .chan(chan),
  .sel_tx_lvl(sel_tx_lvl), .sel_rx_lvl(sel_rx_lvl), .ovf_q(ovf_q), .misuse_q(misuse_q),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
);

// File: tb/test_mbp_top.sv
`timescale 1ns/1ps
module test_mbp_top;
  localparam int NCH = 8;
  localparam int DEPTH = 16;
  localparam logic [31:0] DEV_ID = 32'h51C0_0801;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ack;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] tx_valid, rx_ready;
  logic [NCH-1:0] tx_ready = '0, rx_valid = '0;
  logic [NCH*8-1:0] tx_data;
  logic [NCH*8-1:0] rx_data = '0, rx_stat = '0;

  always #2 clk = ~clk;

  mbp_top #(.NCH(NCH), .DEPTH(DEPTH), .DEV_ID(DEV_ID)) i_mbp_top (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_stat(rx_stat)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [7:0]  txm [NCH][$];
  logic [15:0] rxm [NCH][$];
  logic [NCH-1:0] ovf_m = '0;

  localparam logic [8:0] O_DATA = 9'h100, O_PAIR = 9'h104, O_CHST = 9'h108;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] adr(input int ch, input logic [8:0] off);
    return 12'(ch * 12'h200) + 12'(off);
  endfunction

  task automatic bus(input logic we, input logic [11:0] a, input logic [3:0] be,
                     input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    chk("R1 ack after request", 32'(bus_ack), 32'h1);
    rd = bus_rdata;
    if (we) chk("R1 write rdata zero", rd, 32'h0);
  endtask

  task automatic wr_data(input int ch, input logic [3:0] be, input logic [31:0] wd);
    logic [31:0] rd;
    for (int l = 0; l < 4; l++) begin
      if (be[l]) begin
        if (txm[ch].size() < DEPTH) txm[ch].push_back(wd[l*8 +: 8]);
        else ovf_m[ch] = 1'b1;
      end
    end
    bus(1'b1, adr(ch, O_DATA), be, wd, rd);
  endtask

  task automatic rd_data(input int ch, input logic [3:0] be);
    logic [31:0] rd, exp;
    logic [15:0] e;
    exp = '0;
    for (int l = 0; l < 4; l++) begin
      if (be[l] && rxm[ch].size() > 0) begin
        e = rxm[ch].pop_front();
        exp[l*8 +: 8] = e[7:0];
      end
    end
    bus(1'b0, adr(ch, O_DATA), be, 32'h0, rd);
    chk("R5 data-port read lanes", rd, exp);
  endtask

  task automatic rd_pair(input int ch, input logic [3:0] be);
    logic [31:0] rd, exp;
    int np, base;
    exp = '0;
    np = (be == 4'hF) ? 2 : ((be == 4'h3 || be == 4'hC) ? 1 : 0);
    base = (be == 4'hC) ? 2 : 0;
    for (int k = 0; k < np; k++) begin
      if (rxm[ch].size() > 0) exp[(base + 2*k)*8 +: 16] = rxm[ch].pop_front();
    end
    bus(1'b0, adr(ch, O_PAIR), be, 32'h0, rd);
    if (np == 0) chk("R7 misuse read returns zero", rd, 32'h0);
    else chk("R6 paired read", rd, exp);
  endtask

  task automatic chk_status(input int ch);
    logic [31:0] rd;
    bus(1'b0, adr(ch, O_CHST), 4'hF, 32'h0, rd);
    chk("R10 channel status levels", rd, 32'(txm[ch].size()) | (32'(rxm[ch].size()) << 8));
  endtask

  task automatic rx_push(input int ch, input logic [7:0] d, input logic [7:0] s);
    @(negedge clk);
    if (rx_ready[ch]) rxm[ch].push_back({s, d});
    rx_valid[ch] = 1'b1;
    rx_data[ch*8 +: 8] = d;
    rx_stat[ch*8 +: 8] = s;
    @(negedge clk);
    rx_valid[ch] = 1'b0;
  endtask

  task automatic tx_drain(input int ch);
    @(negedge clk);
    tx_ready[ch] = 1'b1;
    for (int i = 0; i < 64; i++) begin
      if (!tx_valid[ch]) break;
      if (txm[ch].size() == 0) chk("R8 unexpected tx byte", 32'(tx_data[ch*8 +: 8]), 32'hx);
      else chk("R3 R8 tx byte order", 32'(tx_data[ch*8 +: 8]), 32'(txm[ch].pop_front()));
      @(negedge clk);
    end
    tx_ready[ch] = 1'b0;
    chk("R8 tx queue drained", 32'(txm[ch].size()), 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] rd;
    chk("R1 no ack in reset", 32'(bus_ack), 32'h0);
    chk("R8 tx_valid low after reset", 32'(tx_valid), 32'h0);
    chk("R9 rx_ready high after reset", 32'(rx_ready), 32'hFF);
    chk_status(0);
    bus(1'b0, adr(0, 9'h084), 4'hF, 32'h0, rd);
    chk("R4 overflow flags clear after reset", rd, 32'h0);
  endtask

  task automatic t_tx_widths();
    wr_data(3, 4'h1, 32'h0000_00A1);
    wr_data(3, 4'h3, 32'h0000_B2B1);
    wr_data(3, 4'h7, 32'h00C3_C2C1);
    wr_data(3, 4'hF, 32'hD4D3_D2D1);
    wr_data(3, 4'hC, 32'hE2E1_0000);
    wr_data(3, 4'h5, 32'h00F2_00F1);
    chk_status(3);
    @(negedge clk);
    chk("R8 tx valid with data", 32'(tx_valid[3]), 32'h1);
    chk("R8 head byte", 32'(tx_data[3*8 +: 8]), 32'h0000_00A1);
    @(negedge clk);
    chk("R8 head held without ready", 32'(tx_data[3*8 +: 8]), 32'h0000_00A1);
    tx_drain(3);
  endtask

  task automatic t_tx_overflow();
    logic [31:0] rd;
    for (int i = 0; i < 3; i++) wr_data(5, 4'hF, 32'h1010_1010 * (i + 1));
    wr_data(5, 4'h3, 32'h0000_4241);
    bus(1'b0, adr(0, 9'h084), 4'hF, 32'h0, rd);
    chk("R4 no overflow when it fits", rd, 32'h0);
    wr_data(5, 4'hF, 32'h5453_5251);
    chk_status(5);
    bus(1'b0, adr(0, 9'h084), 4'hF, 32'h0, rd);
    chk("R4 overflow flag set", rd, 32'(ovf_m));
    bus(1'b1, adr(0, 9'h084), 4'h1, 32'h0000_0020, rd);
    bus(1'b0, adr(0, 9'h084), 4'hF, 32'h0, rd);
    chk("R4 overflow flag cleared by write-one", rd, 32'h0);
    ovf_m = '0;
    tx_drain(5);
  endtask

  task automatic t_rx_widths();
    for (int i = 0; i < 7; i++) rx_push(2, 8'h30 + 8'(i), 8'h80 + 8'(i));
    chk_status(2);
    rd_data(2, 4'h1);
    rd_data(2, 4'hC);
    rd_data(2, 4'h7);
    rd_data(2, 4'hF);
    chk_status(2);
    rd_data(2, 4'hF);
  endtask

  task automatic t_pair();
    for (int i = 0; i < 3; i++) rx_push(7, 8'h60 + 8'(i), 8'h01 << i);
    rd_pair(7, 4'h3);
    rd_pair(7, 4'hF);
    rx_push(7, 8'h77, 8'h1E);
    rx_push(7, 8'h78, 8'h04);
    rd_pair(7, 4'hC);
    rd_pair(7, 4'hF);
    chk_status(7);
  endtask

  task automatic t_misuse();
    logic [31:0] rd;
    rx_push(6, 8'h9A, 8'h08);
    rd_pair(6, 4'h7);
    chk_status(6);
    bus(1'b0, adr(0, 9'h088), 4'hF, 32'h0, rd);
    chk("R7 misuse flag set", rd, 32'h1);
    rd_pair(6, 4'h1);
    bus(1'b1, adr(0, 9'h088), 4'h1, 32'h1, rd);
    bus(1'b0, adr(0, 9'h088), 4'hF, 32'h0, rd);
    chk("R7 misuse flag cleared", rd, 32'h0);
    rd_pair(6, 4'h3);
  endtask

  task automatic t_decode();
    logic [31:0] rd;
    bus(1'b0, adr(0, 9'h080), 4'hF, 32'h0, rd);
    chk("R11 device id", rd, DEV_ID);
    bus(1'b0, adr(1, 9'h080), 4'hF, 32'h0, rd);
    chk("R2 device range outside channel 0", rd, 32'h0);
    bus(1'b1, adr(0, 9'h08C), 4'hF, 32'hCAFE_F00D, rd);
    bus(1'b1, adr(0, 9'h08C), 4'h2, 32'h0000_5500, rd);
    bus(1'b0, adr(0, 9'h08C), 4'hF, 32'h0, rd);
    chk("R11 scratch byte write", rd, 32'hCAFE_550D);
    bus(1'b1, adr(1, 9'h08C), 4'hF, 32'h1111_1111, rd);
    bus(1'b0, adr(0, 9'h08C), 4'hF, 32'h0, rd);
    chk("R2 write outside channel 0 ignored", rd, 32'hCAFE_550D);
    bus(1'b1, adr(4, 9'h010), 4'hF, 32'hFFFF_FFFF, rd);
    bus(1'b0, adr(4, 9'h010), 4'hF, 32'h0, rd);
    chk("R2 unmapped offset reads zero", rd, 32'h0);
    chk_status(4);
    rx_push(4, 8'h44, 8'h00);
    bus(1'b0, adr(0, 9'h090), 4'hF, 32'h0, rd);
    chk("R11 rx nonempty map", rd, 32'h10);
    rd_data(4, 4'h1);
  endtask

  task automatic t_rx_full();
    for (int i = 0; i < DEPTH; i++) rx_push(1, 8'(i), 8'hF0 ^ 8'(i));
    @(negedge clk);
    chk("R9 rx_ready low when full", 32'(rx_ready[1]), 32'h0);
    rx_push(1, 8'hEE, 8'hEE);
    chk_status(1);
    for (int i = 0; i < DEPTH / 4; i++) rd_data(1, 4'hF);
    @(negedge clk);
    chk("R9 rx_ready high after drain", 32'(rx_ready[1]), 32'h1);
    rd_data(1, 4'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_widths();
    t_tx_overflow();
    t_rx_widths();
    t_pair();
    t_misuse();
    t_decode();
    t_rx_full();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule